// File: doc/BRIEF.md
# Segment-Configured Address Translator

This block turns a 32-bit virtual address into a routing decision for the memory pipeline. It places the address in one of six fixed segments, takes that segment's 16-bit attribute word from one half of three 32-bit control words, and applies the current privilege level. The result is one of three outcomes. The access can raise an address error. It can be handed to a TLB, which lies outside this block. Or it can be translated directly to a physical address with full permissions.

The whole path is combinational, so the outputs follow the inputs in the same cycle. There is no data stream at the block's edge, and so there is no valid/ready pair and no back-pressure. Every pin is a plain level.

The behaviour of each segment is set per privilege through a 3-bit access-mode code, so software can make a region faulting, TLB-mapped or direct-mapped without changing the segment layout.

Top module: `seg_xlate_unit`

## Requirements
- R1: Segment boundaries and offset masks:
  - Addresses 0x00000000–0x3FFFFFFF and 0x40000000–0x7FFFFFFF form two 1 GB segments, each with offset mask 0x3FFFFFFF.
  - Addresses 0x80000000, 0xA0000000, 0xC0000000 and 0xE0000000 each start a 512 MB segment with offset mask 0x1FFFFFFF.
- R2: Each segment takes its attribute word from one half of a control word:
  - 0x00000000 segment: `segcfg2_i[31:16]`; 0x40000000 segment: `segcfg2_i[15:0]`.
  - 0x80000000 segment: `segcfg1_i[31:16]`; 0xA0000000 segment: `segcfg1_i[15:0]`.
  - 0xC0000000 segment: `segcfg0_i[31:16]`; 0xE0000000 segment: `segcfg0_i[15:0]`.
- R3: Attribute word layout: bits 15:9 hold the physical-address field, bits 6:4 the access mode, and bit 3 the error-level-unmapped bit. The other bits are ignored.
- R4: Privilege code 0 (kernel) never raises an address error. It is TLB-mapped exactly for access modes 1, 2 and 3.
- R5: Privilege code 1 (supervisor) raises an address error for modes 0 and 1, and is TLB-mapped for modes 2, 3 and 4.
- R6: Privilege code 2 (user) raises an address error for modes 0, 1, 2 and 5, and is TLB-mapped for modes 3 and 4.
- R7: Privilege code 3 (error level):
  - With the error-level-unmapped bit set, the access is always unmapped and faultless.
  - With the bit clear, the kernel rules of R4 apply.
- R8: An unmapped access forms `paddr_o` in three steps:
  - Take the physical-address field shifted left by 29 bits, which is the attribute word shifted left by 20.
  - Clear the segment's offset bits in it.
  - OR in the virtual address's offset bits. The result is 36 bits wide.
- R9: Flag and output exclusivity:
  - `addr_err_o` and `tlb_map_o` are never both set.
  - When either is set, `perm_o` and `paddr_o` are zero.
  - Otherwise `perm_o` is 3'b111 (bit 0 read, bit 1 write, bit 2 execute).
- R10: Access modes 6 (reserved) and 7 give an unmapped, faultless access at every privilege level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vaddr_i | input | 32 | Virtual address |
| priv_i | input | 2 | Privilege: 0 kernel, 1 supervisor, 2 user, 3 error level |
| segcfg0_i | input | 32 | Attribute words for the 0xC0000000 (high half) and 0xE0000000 (low half) segments |
| segcfg1_i | input | 32 | Attribute words for the 0x80000000 (high half) and 0xA0000000 (low half) segments |
| segcfg2_i | input | 32 | Attribute words for the 0x00000000 (high half) and 0x40000000 (low half) segments |
| addr_err_o | output | 1 | Access raises an address error |
| tlb_map_o | output | 1 | Access must be resolved by the TLB |
| paddr_o | output | 36 | Direct-mapped physical address |
| perm_o | output | 3 | Permission vector: bit 0 read, bit 1 write, bit 2 execute |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 16-bit attribute halves, a 3-bit mode field at bit 4 and a 7-bit physical field at bit 9. With an 8-value mode code, four privilege codes and one unmapped bit, the whole decision space can be swept exhaustively in every segment. The 7-bit physical field makes the all-ones case reachable, which shows that bit 29 of the base is cleared in the 1 GB segments and kept in the 512 MB ones. Addresses on both sides of every segment edge check that the correct half of the correct control word is selected.

// File: rtl/sxu_pkg.sv
package sxu_pkg;
  localparam int VA_W      = 32;
  localparam int CFG_W     = 16;
  localparam int CTL_W     = 2 * CFG_W;
  localparam int NUM_CTL   = 3;
  localparam int NUM_SEG   = 2 * NUM_CTL;
  localparam int SEG_IDX_W = $clog2(NUM_SEG);
  localparam int PAF_LSB   = 9;
  localparam int PAF_W     = 7;
  localparam int AM_LSB    = 4;
  localparam int AM_W      = 3;
  localparam int EU_BIT    = 3;
  localparam int PA_SHIFT  = 20;
  localparam int PA_W      = PAF_LSB + PAF_W + PA_SHIFT;
  localparam int BASE_LSB  = PAF_LSB + PA_SHIFT;
  localparam int NUM_AM    = 1 << AM_W;
  localparam int USEG_OFF_W = VA_W - 2;
  localparam int KSEG_OFF_W = VA_W - 3;
  localparam int PERM_W    = 3;

  typedef enum logic [1:0] {
    PRIV_KERN = 2'd0,
    PRIV_SUPV = 2'd1,
    PRIV_USER = 2'd2,
    PRIV_ERRL = 2'd3
  } priv_e;

  // One bit per access-mode code; bit n set means mode n qualifies.
  localparam logic [NUM_AM-1:0] KERN_TLB_SET = 8'b0000_1110;
  localparam logic [NUM_AM-1:0] SUPV_ADE_SET = 8'b0000_0011;
  localparam logic [NUM_AM-1:0] SUPV_TLB_SET = 8'b0001_1100;
  localparam logic [NUM_AM-1:0] USER_ADE_SET = 8'b0010_0111;
  localparam logic [NUM_AM-1:0] USER_TLB_SET = 8'b0001_1000;

  localparam logic [PERM_W-1:0] PERM_ALL = 3'b111;
endpackage

// File: rtl/sxu_seg_select.sv
module sxu_seg_select
  import sxu_pkg::*;
(
  input  logic [2:0]            top_bits_i,
  input  logic [CTL_W-1:0]      ctl0_i,
  input  logic [CTL_W-1:0]      ctl1_i,
  input  logic [CTL_W-1:0]      ctl2_i,
  output logic [CFG_W-1:0]      cfg_o,
  output logic [VA_W-1:0]       off_mask_o
);
  logic [CTL_W-1:0] ctl [NUM_CTL];
  logic [CFG_W-1:0] half [NUM_SEG];
  logic [SEG_IDX_W-1:0] seg_idx;
  logic user_seg;

  assign ctl[0] = ctl0_i;
  assign ctl[1] = ctl1_i;
  assign ctl[2] = ctl2_i;

  // Segment k reads control word (NUM_CTL-1-k/2); even k takes the high half.
  generate
    for (genvar k = 0; k < NUM_SEG; k++) begin : g_half
      localparam int REG_SEL = NUM_CTL - 1 - k / 2;
      if ((k % 2) == 0) begin : g_hi
        assign half[k] = ctl[REG_SEL][CTL_W-1:CFG_W];
      end else begin : g_lo
        assign half[k] = ctl[REG_SEL][CFG_W-1:0];
      end
    end
  endgenerate

  assign user_seg = ~top_bits_i[2];

  always_comb begin
    if (user_seg) begin
      seg_idx = {{(SEG_IDX_W-1){1'b0}}, top_bits_i[1]};
    end else begin
      seg_idx = SEG_IDX_W'(2) + SEG_IDX_W'(top_bits_i[1:0]);
    end
  end

  assign cfg_o = half[seg_idx];

  always_comb begin
    if (user_seg) begin
      off_mask_o = {{(VA_W-USEG_OFF_W){1'b0}}, {USEG_OFF_W{1'b1}}};
    end else begin
      off_mask_o = {{(VA_W-KSEG_OFF_W){1'b0}}, {KSEG_OFF_W{1'b1}}};
    end
  end
endmodule

// File: rtl/sxu_mode_decode.sv
module sxu_mode_decode
  import sxu_pkg::*;
(
  input  logic [AM_W-1:0] am_i,
  input  logic            eu_i,
  input  logic [1:0]      priv_i,
  output logic            ade_o,
  output logic            tlb_o
);
  priv_e priv;
  assign priv = priv_e'(priv_i);

  always_comb begin
    ade_o = 1'b0;
    tlb_o = 1'b0;
    unique case (priv)
      PRIV_KERN: begin
        tlb_o = KERN_TLB_SET[am_i];
      end
      PRIV_SUPV: begin
        ade_o = SUPV_ADE_SET[am_i];
        tlb_o = SUPV_TLB_SET[am_i] & ~SUPV_ADE_SET[am_i];
      end
      PRIV_USER: begin
        ade_o = USER_ADE_SET[am_i];
        tlb_o = USER_TLB_SET[am_i] & ~USER_ADE_SET[am_i];
      end
      PRIV_ERRL: begin
        tlb_o = ~eu_i & KERN_TLB_SET[am_i];
      end
      default: begin
        ade_o = 1'b0;
        tlb_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sxu_phys_form.sv
module sxu_phys_form
  import sxu_pkg::*;
(
  input  logic [VA_W-1:0]   va_i,
  input  logic [VA_W-1:0]   off_mask_i,
  input  logic [PAF_W-1:0]  pa_field_i,
  input  logic              ade_i,
  input  logic              tlb_i,
  output logic [PA_W-1:0]   paddr_o,
  output logic [PERM_W-1:0] perm_o
);
  logic [PA_W-1:0] base_raw;
  logic [PA_W-1:0] mask_ext;
  logic [PA_W-1:0] direct_pa;
  logic            blocked;

  assign base_raw  = {pa_field_i, {BASE_LSB{1'b0}}};
  assign mask_ext  = {{(PA_W-VA_W){1'b0}}, off_mask_i};
  assign direct_pa = (base_raw & ~mask_ext) | ({{(PA_W-VA_W){1'b0}}, va_i} & mask_ext);
  assign blocked   = ade_i | tlb_i;

  assign paddr_o = blocked ? '0 : direct_pa;
  assign perm_o  = blocked ? '0 : PERM_ALL;
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import sxu_pkg::*;
(
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [1:0]        priv_i,
  input  logic [CTL_W-1:0]  segcfg0_i,
  input  logic [CTL_W-1:0]  segcfg1_i,
  input  logic [CTL_W-1:0]  segcfg2_i,
  output logic              addr_err_o,
  output logic              tlb_map_o,
  output logic [PA_W-1:0]   paddr_o,
  output logic [PERM_W-1:0] perm_o
);
  logic [CFG_W-1:0] seg_cfg;
  logic [VA_W-1:0]  off_mask;
  logic             ade;
  logic             tlb;

  sxu_seg_select u_sel (
    .top_bits_i (vaddr_i[VA_W-1:VA_W-3]),
    .ctl0_i     (segcfg0_i),
    .ctl1_i     (segcfg1_i),
    .ctl2_i     (segcfg2_i),
    .cfg_o      (seg_cfg),
    .off_mask_o (off_mask)
  );

  sxu_mode_decode u_dec (
    .am_i   (seg_cfg[AM_LSB +: AM_W]),
    .eu_i   (seg_cfg[EU_BIT]),
    .priv_i (priv_i),
    .ade_o  (ade),
    .tlb_o  (tlb)
  );

  sxu_phys_form u_pf (
    .va_i       (vaddr_i),
    .off_mask_i (off_mask),
    .pa_field_i (seg_cfg[PAF_LSB +: PAF_W]),
    .ade_i      (ade),
    .tlb_i      (tlb),
    .paddr_o    (paddr_o),
    .perm_o     (perm_o)
  );

  assign addr_err_o = ade;
  assign tlb_map_o  = tlb;
endmodule

// File: rtl/sxu_chk.sv
module sxu_chk
  import sxu_pkg::*;
(
  input logic [VA_W-1:0]   vaddr,
  input logic [1:0]        priv,
  input logic [CFG_W-1:0]  cfg,
  input logic              addr_err,
  input logic              tlb_map,
  input logic [PA_W-1:0]   paddr,
  input logic [PERM_W-1:0] perm
);
  logic [AM_W-1:0] am;
  logic            flagged;
  assign am      = cfg[AM_LSB +: AM_W];
  assign flagged = addr_err | tlb_map;

  always_comb begin
    AST_CFG_KNOWN: assert (!$isunknown(cfg)); // R2
    AST_FLAGS_EXCL: assert (!(addr_err && tlb_map)); // R9
    AST_PERM_BLOCKED: assert (!flagged || (perm == '0 && paddr == '0)); // R9
    AST_PERM_OPEN: assert (flagged || perm == PERM_ALL); // R9
    AST_KERN_NO_ADE: assert (priv != 2'd0 || !addr_err); // R4
    AST_ERRL_UNMAP: assert (!(priv == 2'd3 && cfg[EU_BIT]) || !flagged); // R7
    AST_USER_ADE: assert (!(priv == 2'd2 && (am <= 3'd2 || am == 3'd5)) || addr_err); // R6
    AST_RSVD_UNMAP: assert (am < 3'd6 || !flagged); // R10
    AST_OFFSET_PASS: assert (flagged || paddr[KSEG_OFF_W-1:0] == vaddr[KSEG_OFF_W-1:0]); // R8
  end
endmodule

bind seg_xlate_unit sxu_chk u_chk (
  .vaddr    (vaddr_i),
  .priv     (priv_i),
  .cfg      (seg_cfg),
  .addr_err (addr_err_o),
  .tlb_map  (tlb_map_o),
  .paddr    (paddr_o),
  .perm     (perm_o)
);

// File: tb/sim_seg_xlate_unit.sv
module sim_seg_xlate_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] vaddr = '0;
  logic [1:0]  priv = '0;
  logic [31:0] c0 = '0, c1 = '0, c2 = '0;
  logic        ade, tlb;
  logic [35:0] pa;
  logic [2:0]  perm;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct {
    logic        ade;
    logic        tlb;
    logic [35:0] pa;
    logic [2:0]  perm;
    string       req;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  seg_xlate_unit u0 (
    .vaddr_i(vaddr), .priv_i(priv),
    .segcfg0_i(c0), .segcfg1_i(c1), .segcfg2_i(c2),
    .addr_err_o(ade), .tlb_map_o(tlb), .paddr_o(pa), .perm_o(perm)
  );

  function automatic logic [15:0] mkcfg(input logic [6:0] paf, input logic [2:0] am, input logic eu);
    return {paf, 2'b00, am, eu, 3'b000};
  endfunction

  function automatic exp_t model(input logic [31:0] va, input logic [1:0] pv,
                                 input logic [31:0] r0, input logic [31:0] r1,
                                 input logic [31:0] r2, input string req);
    exp_t e;
    logic [15:0] cfg;
    logic [31:0] msk;
    logic [2:0]  am;
    logic [35:0] base;
    if (va < 32'h4000_0000)      begin cfg = r2[31:16]; msk = 32'h3FFF_FFFF; end
    else if (va < 32'h8000_0000) begin cfg = r2[15:0];  msk = 32'h3FFF_FFFF; end
    else if (va < 32'hA000_0000) begin cfg = r1[31:16]; msk = 32'h1FFF_FFFF; end
    else if (va < 32'hC000_0000) begin cfg = r1[15:0];  msk = 32'h1FFF_FFFF; end
    else if (va < 32'hE000_0000) begin cfg = r0[31:16]; msk = 32'h1FFF_FFFF; end
    else                         begin cfg = r0[15:0];  msk = 32'h1FFF_FFFF; end
    am = cfg[6:4];
    e.ade = 1'b0;
    e.tlb = 1'b0;
    case (pv)
      2'd0: e.tlb = (am == 3'd1 || am == 3'd2 || am == 3'd3);
      2'd1: begin e.ade = (am <= 3'd1); e.tlb = (am >= 3'd2 && am <= 3'd4); end
      2'd2: begin e.ade = (am <= 3'd2 || am == 3'd5); e.tlb = (am == 3'd3 || am == 3'd4); end
      default: if (!cfg[3]) e.tlb = (am >= 3'd1 && am <= 3'd3);
    endcase
    base = {cfg[15:9], 29'b0} & ~{4'b0, msk};
    if (e.ade || e.tlb) begin
      e.pa = '0;
      e.perm = 3'b000;
    end else begin
      e.pa = base | {4'b0, va & msk};
      e.perm = 3'b111;
    end
    e.req = req;
    return e;
  endfunction

  task automatic drive(input logic [31:0] va, input logic [1:0] pv,
                       input logic [31:0] r0, input logic [31:0] r1,
                       input logic [31:0] r2, input string req);
    @(posedge clk);
    #1;
    vaddr = va; priv = pv; c0 = r0; c1 = r1; c2 = r2;
    sb.push_back(model(va, pv, r0, r1, r2, req));
  endtask

  // Monitor: compare once per cycle, mid-period.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (ade !== e.ade || tlb !== e.tlb || pa !== e.pa || perm !== e.perm) begin
        n_bad++;
        $display("FAIL %s va=%h priv=%0d: got ade=%b tlb=%b pa=%h perm=%b, exp ade=%b tlb=%b pa=%h perm=%b",
                 e.req, vaddr, priv, ade, tlb, pa, perm, e.ade, e.tlb, e.pa, e.perm);
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // Reset-state inputs: all zero, kernel, mode 0 -> direct map to 0. R8
    drive(32'h0, 2'd0, 32'h0, 32'h0, 32'h0, "R8_reset");

    // R1/R2: distinct physical fields per half, kernel mode 0 (unmapped).
    begin
      logic [31:0] r0, r1, r2;
      logic [31:0] edges [12];
      r2 = {mkcfg(7'h11, 3'd0, 1'b0), mkcfg(7'h22, 3'd0, 1'b0)};
      r1 = {mkcfg(7'h33, 3'd0, 1'b0), mkcfg(7'h44, 3'd0, 1'b0)};
      r0 = {mkcfg(7'h55, 3'd0, 1'b0), mkcfg(7'h66, 3'd0, 1'b0)};
      edges = '{32'h0000_0000, 32'h3FFF_FFFF, 32'h4000_0000, 32'h7FFF_FFFF,
                32'h8000_0000, 32'h9FFF_FFFF, 32'hA000_0000, 32'hBFFF_FFFF,
                32'hC000_0000, 32'hDFFF_FFFF, 32'hE000_0000, 32'hFFFF_FFFF};
      foreach (edges[i]) drive(edges[i], 2'd0, r0, r1, r2, "R1_R2_edges");
      // R3: ignored bits set to ones must not change the outcome.
      drive(32'h1234_5678, 2'd0, r0, r1, r2 | 32'h0187_0187, "R3_ignored_bits");
      // R8: all-ones physical field in 1 GB and 512 MB segments.
      drive(32'h5555_AAAA, 2'd0, 32'h0, 32'h0, {16'h0, mkcfg(7'h7F, 3'd0, 1'b0)}, "R8_base_useg");
      drive(32'hF555_AAAA, 2'd0, {16'h0, mkcfg(7'h7F, 3'd0, 1'b0)}, 32'h0, 32'h0, "R8_base_kseg");
    end

    // Exhaustive mode sweep: privilege x mode x unmapped bit x segment.
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 8; m++) begin
        for (int u = 0; u < 2; u++) begin
          string tag;
          logic [15:0] cf;
          logic [31:0] full;
          if (m >= 6)      tag = "R10_mode67";
          else if (p == 0) tag = "R4_kernel";
          else if (p == 1) tag = "R5_super";
          else if (p == 2) tag = "R6_user";
          else             tag = "R7_errlvl";
          cf = mkcfg(7'(m * 9 + u + 3), 3'(m), 1'(u));
          full = {cf, cf};
          drive(32'h0123_4567, 2'(p), full, full, full, tag);
          drive(32'h6ABC_DEF0, 2'(p), full, full, full, tag);
          drive(32'h9ABC_DEF0, 2'(p), full, full, full, tag);
          drive(32'hE123_4567, 2'(p), full, full, full, tag);
        end
      end
    end
    // R9: flag exclusivity cross-check with mixed configs per segment.
    drive(32'hC000_1000, 2'd1, {mkcfg(7'h01, 3'd1, 1'b0), mkcfg(7'h02, 3'd4, 1'b0)}, 32'h0, 32'h0, "R9_super_ade");
    drive(32'hE000_1000, 2'd1, {mkcfg(7'h01, 3'd1, 1'b0), mkcfg(7'h02, 3'd4, 1'b0)}, 32'h0, 32'h0, "R9_super_tlb");

    wait (sb.size() == 0);
    @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule